// File: doc/BRIEF.md
# Execution-Unit Sleep Controller

This block drives the sleep control of each separately switched execution unit in a five-stage in-order pipeline. There are five units: the integer ALU, the shifter, the multiplier, the divider and the system-control logic. Each cycle the block looks at the instruction class that enters fetch. If that class needs a unit which is asleep, it powers the unit up at once. The fetch and decode cycles then cover the wake-up time before the instruction reaches execute. Each unit has its own programmable wake latency. If a unit is still counting down when its instruction sits in execute, the block raises a stall until the unit is ready.

The return to sleep follows a two-bit strategy register that software sets from the current break-even time. The four strategies are: sleep right after use; sleep on a first-level cache miss; sleep on a second-level cache miss; and second-level misses together with compiler hints carried by the instructions. A unit still held by an instruction in decode, or by a stalled instruction in execute, is never switched off. A wake request in the same cycle always beats a sleep trigger.

Top module: `eu_pgate_ctrl`

## Requirements
- R1: After reset every `unit_sleep` bit is 1, `stall` is 0 and the strategy is 00.
- R2: A class code k (1 ALU, 2 shifter, 3 multiplier, 4 divider, 5 system-control; 0, 6 and 7 mean no unit) at `if_cls` clears `unit_sleep[k-1]` after the next edge if it was set. Other units are not affected.
- R3: A unit woken with latency L is ready L cycles after its sleep bit clears. The instruction reaches execute two edges after fetch, and `stall` is high while the unit of the execute instruction is not ready. With no other stall this costs max(0, L-1) stall cycles. While stalled, the decode and execute contents hold.
- R4: Strategy 00: a unit goes to sleep on the edge at which its instruction leaves execute without stall, unless R8 or R9 applies.
- R5: Strategy 01: units sleep only on an edge with `l1_miss` high. Completion and `l2_miss` do not put a unit to sleep.
- R6: Strategy 10: units sleep only on an edge with `l2_miss` high. Completion and `l1_miss` do not put a unit to sleep.
- R7: Strategy 11: units sleep on `l2_miss`, and a unit also sleeps when its instruction that carried `if_hint`=1 leaves execute. `l1_miss` and unhinted completion are ignored.
- R8: A unit named by the decode instruction, or by a stalled execute instruction, is not put to sleep.
- R9: A unit requested at fetch in a cycle that also carries a sleep trigger stays awake.
- R10: A write through `mode_we`/`mode_wd` takes effect from the next cycle. The encodings are 00 after-use, 01 L1-miss, 10 L2-miss, 11 hint plus L2-miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| if_cls | input | CLS_W | Class of the instruction entering fetch (0 = none) |
| if_hint | input | 1 | Compiler sleep hint attached to the fetched instruction |
| l1_miss | input | 1 | First-level cache miss pulse |
| l2_miss | input | 1 | Second-level cache miss pulse |
| mode_we | input | 1 | Strategy register write enable |
| mode_wd | input | 2 | Strategy register write data |
| wake_lat | input | NUM_UNITS*LAT_W | Per-unit wake latency, unit i at bits [i*LAT_W +: LAT_W] |
| unit_sleep | output | NUM_UNITS | 1 = unit switched off |
| stall | output | 1 | Hold request while the execute instruction's unit is not ready |

## Verification
A vector table under the after-use strategy covers three cases. Isolated instructions tell an immediate return to sleep apart from a late one. Back-to-back instructions to one unit separate correct in-use protection from a premature switch-off. Units with latencies 0 to 3 tell hidden wake-up from exact stall lengths. Directed runs under each other strategy show that only the matching trigger switches units off: the wrong miss pulse or an unhinted completion must leave them on. Further runs apply a miss while the unit sits in decode, and while fetch requests the same unit.

// File: rtl/eu_pg_pkg.sv
package eu_pg_pkg;
   typedef enum logic [1:0] {
      PG_AFTER_USE = 2'b00,
      PG_ON_L1     = 2'b01,
      PG_ON_L2     = 2'b10,
      PG_HINT_L2   = 2'b11
   } pg_mode_e;

   localparam int PG_UNITS = 5;
   localparam int PG_LAT_W = 4;
endpackage

// File: rtl/eu_pg_decode.sv
module eu_pg_decode #(
   parameter int NUM_UNITS = 5,
   parameter int CLS_W     = $clog2(NUM_UNITS + 1)
) (
   input  logic [CLS_W-1:0]     cls,
   output logic [NUM_UNITS-1:0] need
);
   if ((1 << CLS_W) < NUM_UNITS + 1) begin : g_bad_w
      $error("class field too narrow for unit count");
   end

   for (genvar i = 0; i < NUM_UNITS; i++) begin : g_dec
      assign need[i] = (cls == CLS_W'(i + 1));
   end
endmodule

// File: rtl/eu_pg_pipe.sv
module eu_pg_pipe #(
   parameter int NUM_UNITS = 5
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_UNITS-1:0] if_need,
   input  logic                 if_hint,
   input  logic                 stall,
   output logic [NUM_UNITS-1:0] id_need,
   output logic [NUM_UNITS-1:0] ex_need,
   output logic                 ex_hint
);
   logic id_hint;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         id_need <= '0;
         ex_need <= '0;
         id_hint <= 1'b0;
         ex_hint <= 1'b0;
      end else if (!stall) begin
         id_need <= if_need;
         id_hint <= if_hint;
         ex_need <= id_need;
         ex_hint <= id_hint;
      end
   end

   assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      stall |=> ($stable(ex_need) && $stable(id_need)));
   assert_single_ex_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(ex_need));
endmodule

// File: rtl/eu_pg_policy.sv
module eu_pg_policy
   import eu_pg_pkg::*;
#(
   parameter int NUM_UNITS = 5
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  pg_mode_e             mode,
   input  logic                 l1_miss,
   input  logic                 l2_miss,
   input  logic [NUM_UNITS-1:0] done,
   input  logic                 done_hint,
   output logic [NUM_UNITS-1:0] sleep_req
);
   always_comb begin
      unique case (mode)
         PG_AFTER_USE: sleep_req = done;
         PG_ON_L1:     sleep_req = {NUM_UNITS{l1_miss}};
         PG_ON_L2:     sleep_req = {NUM_UNITS{l2_miss}};
         default:      sleep_req = {NUM_UNITS{l2_miss}} | (done & {NUM_UNITS{done_hint}});
      endcase
   end

   assert_after_use_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == PG_AFTER_USE) |-> ((sleep_req & ~done) == '0));
   assert_l1_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == PG_ON_L1 && sleep_req != '0) |-> l1_miss);
endmodule

// File: rtl/eu_pg_unit.sv
module eu_pg_unit #(
   parameter int LAT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wake_req,
   input  logic             sleep_req,
   input  logic             in_use,
   input  logic [LAT_W-1:0] lat,
   output logic             sleep,
   output logic             ready
);
   logic [LAT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sleep <= 1'b1;
         cnt_q <= '0;
      end else if (wake_req && sleep) begin
         sleep <= 1'b0;
         cnt_q <= lat;
      end else if (!sleep && cnt_q != '0) begin
         cnt_q <= cnt_q - LAT_W'(1);
      end else if (sleep_req && !wake_req && !in_use && !sleep) begin
         sleep <= 1'b1;
      end
   end

   assign ready = !sleep && (cnt_q == '0);

   assert_wake_prio_R9: assert property (@(posedge clk) disable iff (!rst_n)
      wake_req |=> !sleep);
   assert_in_use_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (in_use && !sleep) |=> !sleep);
   assert_countdown_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!sleep && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - LAT_W'(1)));
endmodule

// File: rtl/eu_pgate_ctrl.sv
module eu_pgate_ctrl
   import eu_pg_pkg::*;
#(
   parameter int NUM_UNITS = PG_UNITS,
   parameter int LAT_W     = PG_LAT_W,
   parameter int CLS_W     = $clog2(NUM_UNITS + 1)
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [CLS_W-1:0]           if_cls,
   input  logic                       if_hint,
   input  logic                       l1_miss,
   input  logic                       l2_miss,
   input  logic                       mode_we,
   input  logic [1:0]                 mode_wd,
   input  logic [NUM_UNITS*LAT_W-1:0] wake_lat,
   output logic [NUM_UNITS-1:0]       unit_sleep,
   output logic                       stall
);
   if (NUM_UNITS < 1) begin : g_bad_n
      $error("NUM_UNITS must be at least 1");
   end
   if (LAT_W < 1) begin : g_bad_lat
      $error("LAT_W must be at least 1");
   end

   pg_mode_e               mode_q;
   logic [NUM_UNITS-1:0]   if_need, id_need, ex_need;
   logic [NUM_UNITS-1:0]   ready, in_use, done, sleep_req;
   logic                   ex_hint;

   always_ff @(posedge clk) begin
      if (!rst_n)       mode_q <= PG_AFTER_USE;
      else if (mode_we) mode_q <= pg_mode_e'(mode_wd);
   end

   eu_pg_decode #(.NUM_UNITS(NUM_UNITS), .CLS_W(CLS_W)) u_dec (
      .cls  (if_cls),
      .need (if_need)
   );

   eu_pg_pipe #(.NUM_UNITS(NUM_UNITS)) u_pipe (
      .clk     (clk),
      .rst_n   (rst_n),
      .if_need (if_need),
      .if_hint (if_hint),
      .stall   (stall),
      .id_need (id_need),
      .ex_need (ex_need),
      .ex_hint (ex_hint)
   );

   assign stall  = |(ex_need & ~ready);
   assign in_use = id_need | (ex_need & {NUM_UNITS{stall}});
   assign done   = ex_need & {NUM_UNITS{!stall}};

   eu_pg_policy #(.NUM_UNITS(NUM_UNITS)) u_pol (
      .clk       (clk),
      .rst_n     (rst_n),
      .mode      (mode_q),
      .l1_miss   (l1_miss),
      .l2_miss   (l2_miss),
      .done      (done),
      .done_hint (ex_hint),
      .sleep_req (sleep_req)
   );

   for (genvar i = 0; i < NUM_UNITS; i++) begin : g_unit
      eu_pg_unit #(.LAT_W(LAT_W)) u_unit (
         .clk       (clk),
         .rst_n     (rst_n),
         .wake_req  (if_need[i]),
         .sleep_req (sleep_req[i]),
         .in_use    (in_use[i]),
         .lat       (wake_lat[i*LAT_W +: LAT_W]),
         .sleep     (unit_sleep[i]),
         .ready     (ready[i])
      );
   end

   assert_stall_only_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
      stall |-> (ex_need != '0));
endmodule

// File: tb/tb_eu_pgate_ctrl.sv
module tb_eu_pgate_ctrl;
   localparam int CLK_P = 10;
   localparam int NV    = 20;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] if_cls = '0;
   logic       if_hint = 1'b0, l1_miss = 1'b0, l2_miss = 1'b0;
   logic       mode_we = 1'b0;
   logic [1:0] mode_wd = '0;
   logic [19:0] wake_lat = {4'd1, 4'd0, 4'd3, 4'd2, 4'd1};
   logic [4:0] unit_sleep;
   logic       stall;
   int         checks = 0, errors = 0;

   always #(CLK_P/2) clk = ~clk;

   eu_pgate_ctrl dut (
      .clk(clk), .rst_n(rst_n), .if_cls(if_cls), .if_hint(if_hint),
      .l1_miss(l1_miss), .l2_miss(l2_miss), .mode_we(mode_we),
      .mode_wd(mode_wd), .wake_lat(wake_lat),
      .unit_sleep(unit_sleep), .stall(stall)
   );

   // row: cls, hint, l1, l2, expected sleep, expected stall (after next edge)
   // strategy 00; covers R2 wake, R3 latency/stall, R4 sleep after use,
   // R8 decode protection and R9 same-cycle request
   localparam logic [11:0] VEC [NV] = '{
      {3'd1, 3'b000, 5'b11110, 1'b0},
      {3'd0, 3'b000, 5'b11110, 1'b0},
      {3'd0, 3'b000, 5'b11111, 1'b0},
      {3'd2, 3'b000, 5'b11101, 1'b0},
      {3'd0, 3'b000, 5'b11101, 1'b1},
      {3'd0, 3'b000, 5'b11101, 1'b0},
      {3'd0, 3'b000, 5'b11111, 1'b0},
      {3'd1, 3'b000, 5'b11110, 1'b0},
      {3'd1, 3'b000, 5'b11110, 1'b0},
      {3'd1, 3'b000, 5'b11110, 1'b0},
      {3'd0, 3'b000, 5'b11110, 1'b0},
      {3'd0, 3'b000, 5'b11111, 1'b0},
      {3'd4, 3'b000, 5'b10111, 1'b0},
      {3'd0, 3'b000, 5'b10111, 1'b0},
      {3'd0, 3'b000, 5'b11111, 1'b0},
      {3'd3, 3'b000, 5'b11011, 1'b0},
      {3'd0, 3'b000, 5'b11011, 1'b1},
      {3'd0, 3'b000, 5'b11011, 1'b1},
      {3'd0, 3'b000, 5'b11011, 1'b0},
      {3'd0, 3'b000, 5'b11111, 1'b0}
   };

   task automatic chk(input string tag, input logic [4:0] act, input logic [4:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%b expected=%b", tag, act, exp);
      end
   endtask

   task automatic tick(input logic [2:0] c, input logic h, input logic m1, input logic m2);
      if_cls = c; if_hint = h; l1_miss = m1; l2_miss = m2;
      @(posedge clk);
      @(negedge clk);
      if_cls = '0; if_hint = 1'b0; l1_miss = 1'b0; l2_miss = 1'b0;
   endtask

   task automatic set_mode(input logic [1:0] m);
      mode_we = 1'b1; mode_wd = m;
      tick(3'd0, 1'b0, 1'b0, 1'b0);
      mode_we = 1'b0;
   endtask

   initial begin
      #(CLK_P * 100000);
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      chk("R1 reset sleep", unit_sleep, 5'b11111);
      chk("R1 reset stall", {4'b0, stall}, 5'b0);

      for (int k = 0; k < NV; k++) begin
         tick(VEC[k][11:9], VEC[k][8], VEC[k][7], VEC[k][6]);
         chk($sformatf("R2 R4 R8 R9 table row %0d sleep", k), unit_sleep, VEC[k][5:1]);
         chk($sformatf("R3 table row %0d stall", k), {4'b0, stall}, {4'b0, VEC[k][0]});
      end

      // R10 + R5: strategy 01
      set_mode(2'b01);
      tick(3'd1, 0, 0, 0);
      repeat (3) tick(3'd0, 0, 0, 0);
      chk("R5 R10 no sleep after use", unit_sleep, 5'b11110);
      tick(3'd0, 0, 0, 1);
      chk("R5 l2 ignored", unit_sleep, 5'b11110);
      tick(3'd0, 0, 1, 0);
      chk("R5 l1 sleeps", unit_sleep, 5'b11111);

      // R6: strategy 10
      set_mode(2'b10);
      tick(3'd1, 0, 0, 0);
      repeat (3) tick(3'd0, 0, 0, 0);
      chk("R6 no sleep after use", unit_sleep, 5'b11110);
      tick(3'd1, 0, 0, 1);
      chk("R9 request beats l2", unit_sleep, 5'b11110);
      tick(3'd0, 0, 1, 0);
      chk("R6 l1 ignored", unit_sleep, 5'b11110);
      tick(3'd0, 0, 0, 1);
      chk("R6 l2 sleeps", unit_sleep, 5'b11111);

      // R8: divider held in decode during l2 miss
      tick(3'd4, 0, 0, 0);
      chk("R2 divider woken", unit_sleep, 5'b10111);
      tick(3'd0, 0, 0, 1);
      chk("R8 decode holds divider", unit_sleep, 5'b10111);
      tick(3'd0, 0, 0, 1);
      chk("R8 released then sleeps", unit_sleep, 5'b11111);

      // R7: strategy 11
      set_mode(2'b11);
      tick(3'd1, 0, 0, 0);
      repeat (3) tick(3'd0, 0, 0, 0);
      chk("R7 unhinted stays", unit_sleep, 5'b11110);
      tick(3'd0, 0, 1, 0);
      chk("R7 l1 ignored", unit_sleep, 5'b11110);
      tick(3'd0, 0, 0, 1);
      chk("R7 l2 sleeps", unit_sleep, 5'b11111);
      tick(3'd2, 1, 0, 0);
      tick(3'd0, 0, 0, 0);
      chk("R7 hinted in execute", unit_sleep, 5'b11101);
      chk("R3 shifter stall", {4'b0, stall}, 5'b00001);
      tick(3'd0, 0, 0, 0);
      chk("R7 held while stalled", unit_sleep, 5'b11101);
      tick(3'd0, 0, 0, 0);
      chk("R7 hint sleeps", unit_sleep, 5'b11111);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule